// File: doc/BRIEF.md
# Variable Block Size SAD Tree

This block scores one reference candidate against a 16x16 current macroblock for every partition shape a block-based video encoder may choose, and does so in one pass. Each cycle it takes one row of sixteen current pixels and the sixteen reference pixels at the same position under the candidate's motion vector. It forms the per-pixel absolute differences and accumulates them into sixteen 4x4 sums of absolute differences (SADs).

No larger cost is computed from pixels. The 8x4, 4x8, 8x8, 16x8, 8x16 and 16x16 costs come from an adder tree over the sixteen 4x4 sums. All 41 costs therefore describe the same candidate and become available together. The search controller pulses `start`, streams sixteen valid rows, waits for `done`, and then reads all 41 costs. The costs stay stable until the next `start`.

Top module: `vbsSadTree`

## Requirements
- R1: While reset is held and after it is released, `done` is low and every cost output is zero until rows are accepted.
- R2: Pixel column x (0..15) of a row lies at bits [8x+7:8x] of `curRow` and `refRow`, and the first accepted row after a clear is row y=0. Cost `sad4x4` index k sits at bits [12k+11:12k] and equals the sum of |cur-ref| over columns 4(k mod 4)..+3 and rows 4(k div 4)..+3.
- R3: Index j of `sad8x4` (13 bits each) covers columns 8(j mod 2)..+7 and rows 4(j div 2)..+3. Index j of `sad4x8` (13 bits each) covers columns 4(j mod 4)..+3 and rows 8(j div 4)..+7.
- R4: Index q of `sad8x8` (14 bits each) covers columns 8(q mod 2)..+7 and rows 8(q div 2)..+7. Index h of `sad16x8` (15 bits) covers all columns of rows 8h..+7. Index v of `sad8x16` (15 bits) covers columns 8v..+7 of all rows. `sad16x16` (16 bits) covers the whole block.
- R5: `done` is high for exactly one cycle: the cycle after the 16th accepted row is sampled. All 41 costs are final in that cycle.
- R6: After the 16th accepted row, further rows are ignored, and all costs hold their values until the next `start`.
- R7: A row presented with `rowValid` low is ignored, whatever its pixel values.
- R8: `start` clears all costs to zero and restarts at row 0 from the next cycle. A row presented in the same cycle as `start` is discarded.
- R9: With the largest differences (every |cur-ref| = 255), the costs reach 4080 per 4x4 block and 65280 for 16x16, without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clear pulse for a new candidate |
| rowValid | input | 1 | Row qualifier |
| curRow | input | 128 | Sixteen current pixels of one row |
| refRow | input | 128 | Sixteen reference pixels of one row |
| done | output | 1 | One-cycle pulse when all costs are final |
| sad4x4 | output | 192 | Sixteen 12-bit 4x4 costs |
| sad8x4 | output | 104 | Eight 13-bit 8-wide 4-tall costs |
| sad4x8 | output | 104 | Eight 13-bit 4-wide 8-tall costs |
| sad8x8 | output | 56 | Four 14-bit 8x8 costs |
| sad16x8 | output | 30 | Two 15-bit 16-wide 8-tall costs |
| sad8x16 | output | 30 | Two 15-bit 8-wide 16-tall costs |
| sad16x16 | output | 16 | Whole-macroblock cost |

## Verification
The hardest case to reach from the ports is a row stream that is interrupted: idle cycles carrying junk pixels, extra rows after the block is complete, and a `start` that arrives together with a valid row. Each of these must leave the partition costs untouched. The directed tasks insert gaps of varying length filled with random junk, feed rows beyond the sixteenth, and raise `start` with a live row. They then compare all 41 costs against a reference that sums each rectangle directly from the pixel arrays. The block data use a random pattern, in which a mix-up of partition indices shows up as a wrong cost.

// File: rtl/vbsSadPkg.sv
package vbsSadPkg;
  localparam int MB_DIM      = 16;
  localparam int BLK_DIM     = 4;
  localparam int BLK_PER_ROW = MB_DIM / BLK_DIM;
  localparam int NUM_BLK     = BLK_PER_ROW * BLK_PER_ROW;
  localparam int ROW_CNT_W   = $clog2(MB_DIM) + 1;
  localparam int BROW_W      = $clog2(BLK_PER_ROW);

  typedef struct packed {
    logic              clearAcc;
    logic              addRow;
    logic [BROW_W-1:0] blkRow;
  } sadStrb_t;
endpackage

// File: rtl/vbsSadCtrl.sv
module vbsSadCtrl
  import vbsSadPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     rowValid,
  output sadStrb_t strb,
  output logic     done
);
  localparam logic [ROW_CNT_W-1:0] LAST_ROW = ROW_CNT_W'(MB_DIM - 1);
  localparam logic [ROW_CNT_W-1:0] FULL     = ROW_CNT_W'(MB_DIM);

  logic [ROW_CNT_W-1:0] rowCnt;
  logic accept;

  assign accept = rowValid && !start && (rowCnt != FULL);

  always_comb begin
    strb.clearAcc = start;
    strb.addRow   = accept;
    strb.blkRow   = rowCnt[ROW_CNT_W-2 -: BROW_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= accept && (rowCnt == LAST_ROW);
      if (start)       rowCnt <= '0;
      else if (accept) rowCnt <= rowCnt + 1'b1;
    end
  end
endmodule

// File: rtl/vbsSadDatapath.sv
module vbsSadDatapath
  import vbsSadPkg::*;
#(
  parameter int PIX_W = 8,
  localparam int W44  = PIX_W + 4,
  localparam int W84  = W44 + 1,
  localparam int W88  = W44 + 2,
  localparam int W168 = W44 + 3,
  localparam int W16  = W44 + 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sadStrb_t                strb,
  input  logic [MB_DIM*PIX_W-1:0] curRow,
  input  logic [MB_DIM*PIX_W-1:0] refRow,
  output logic [NUM_BLK*W44-1:0]  sad4x4,
  output logic [8*W84-1:0]        sad8x4,
  output logic [8*W84-1:0]        sad4x8,
  output logic [4*W88-1:0]        sad8x8,
  output logic [2*W168-1:0]       sad16x8,
  output logic [2*W168-1:0]       sad8x16,
  output logic [W16-1:0]          sad16x16
);
  localparam int PART_W = PIX_W + 2;

  logic [PIX_W-1:0]  absDiff [MB_DIM];
  logic [PART_W-1:0] rowPart [BLK_PER_ROW];
  logic [W44-1:0]    acc     [NUM_BLK];
  logic [W84-1:0]    s84     [8];
  logic [W84-1:0]    s48     [8];
  logic [W88-1:0]    s88     [4];
  logic [W168-1:0]   s168    [2];
  logic [W168-1:0]   s816    [2];

  for (genvar p = 0; p < MB_DIM; p++) begin : gDiff
    logic [PIX_W-1:0] c, r;
    assign c = curRow[p*PIX_W +: PIX_W];
    assign r = refRow[p*PIX_W +: PIX_W];
    assign absDiff[p] = (c > r) ? (c - r) : (r - c);
  end

  for (genvar g = 0; g < BLK_PER_ROW; g++) begin : gRowPart
    assign rowPart[g] = PART_W'(absDiff[4*g])   + PART_W'(absDiff[4*g+1])
                      + PART_W'(absDiff[4*g+2]) + PART_W'(absDiff[4*g+3]);
  end

  for (genvar k = 0; k < NUM_BLK; k++) begin : gAcc
    localparam logic [BROW_W-1:0] MY_ROW = BROW_W'(k / BLK_PER_ROW);
    always_ff @(posedge clk) begin
      if (!rstN || strb.clearAcc) acc[k] <= '0;
      else if (strb.addRow && strb.blkRow == MY_ROW)
        acc[k] <= acc[k] + W44'(rowPart[k % BLK_PER_ROW]);
    end
    assign sad4x4[k*W44 +: W44] = acc[k];
  end

  for (genvar j = 0; j < 8; j++) begin : gPairs
    assign s84[j] = W84'(acc[2*j]) + W84'(acc[2*j+1]);
    assign s48[j] = W84'(acc[8*(j/4) + (j%4)]) + W84'(acc[8*(j/4) + (j%4) + 4]);
    assign sad8x4[j*W84 +: W84] = s84[j];
    assign sad4x8[j*W84 +: W84] = s48[j];
  end

  for (genvar q = 0; q < 4; q++) begin : gQuad
    assign s88[q] = W88'(s84[4*(q/2) + (q%2)]) + W88'(s84[4*(q/2) + (q%2) + 2]);
    assign sad8x8[q*W88 +: W88] = s88[q];
  end

  for (genvar h = 0; h < 2; h++) begin : gHalf
    assign s168[h] = W168'(s88[2*h]) + W168'(s88[2*h+1]);
    assign s816[h] = W168'(s88[h])   + W168'(s88[h+2]);
    assign sad16x8[h*W168 +: W168] = s168[h];
    assign sad8x16[h*W168 +: W168] = s816[h];
  end

  assign sad16x16 = W16'(s168[0]) + W16'(s168[1]);
endmodule

// File: rtl/vbsSadTree.sv
module vbsSadTree
  import vbsSadPkg::*;
#(
  parameter int PIX_W = 8,
  localparam int W44  = PIX_W + 4,
  localparam int W84  = W44 + 1,
  localparam int W88  = W44 + 2,
  localparam int W168 = W44 + 3,
  localparam int W16  = W44 + 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    rowValid,
  input  logic [MB_DIM*PIX_W-1:0] curRow,
  input  logic [MB_DIM*PIX_W-1:0] refRow,
  output logic                    done,
  output logic [NUM_BLK*W44-1:0]  sad4x4,
  output logic [8*W84-1:0]        sad8x4,
  output logic [8*W84-1:0]        sad4x8,
  output logic [4*W88-1:0]        sad8x8,
  output logic [2*W168-1:0]       sad16x8,
  output logic [2*W168-1:0]       sad8x16,
  output logic [W16-1:0]          sad16x16
);
  sadStrb_t strb;

  vbsSadCtrl ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rowValid(rowValid),
    .strb(strb), .done(done)
  );

  vbsSadDatapath #(.PIX_W(PIX_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .curRow(curRow), .refRow(refRow),
    .sad4x4(sad4x4), .sad8x4(sad8x4), .sad4x8(sad4x8), .sad8x8(sad8x8),
    .sad16x8(sad16x8), .sad8x16(sad8x16), .sad16x16(sad16x16)
  );
endmodule

// File: rtl/vbsSadChecker.sv
module vbsSadChecker
  import vbsSadPkg::*;
#(
  parameter int PIX_W = 8,
  localparam int W44  = PIX_W + 4,
  localparam int W88  = W44 + 2,
  localparam int W16  = W44 + 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   rowValid,
  input logic                   done,
  input logic [NUM_BLK*W44-1:0] sad4x4,
  input logic [4*W88-1:0]       sad8x8,
  input logic [W16-1:0]         sad16x16
);
  localparam int TOT_W = W16 + 4;

  logic heldFlag;
  logic [TOT_W-1:0] blkTotal;

  always_ff @(posedge clk) begin
    if (!rstN || start) heldFlag <= 1'b0;
    else if (done)      heldFlag <= 1'b1;
  end

  always_comb begin
    blkTotal = '0;
    for (int k = 0; k < NUM_BLK; k++)
      blkTotal = blkTotal + TOT_W'(sad4x4[k*W44 +: W44]);
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5

  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (heldFlag && !start) |=> ($stable(sad4x4) && $stable(sad16x16) && !done)); // R6

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (!rowValid && !start) |=> ($stable(sad4x4) && $stable(sad8x8))); // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> ((sad4x4 == '0) && (sad16x16 == '0) && !done)); // R8

  AST_TREE_TOTAL: assert property (@(posedge clk) disable iff (!rstN)
    blkTotal == TOT_W'(sad16x16)); // R4
endmodule

bind vbsSadTree vbsSadChecker #(.PIX_W(PIX_W)) chk (
  .clk(clk), .rstN(rstN), .start(start), .rowValid(rowValid), .done(done),
  .sad4x4(sad4x4), .sad8x8(sad8x8), .sad16x16(sad16x16)
);

// File: tb/vbsSadTree_test.sv
module vbsSadTree_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic rowValid = 1'b0;
  logic [127:0] curRow = '0;
  logic [127:0] refRow = '0;
  logic done;
  logic [191:0] sad4x4;
  logic [103:0] sad8x4, sad4x8;
  logic [55:0]  sad8x8;
  logic [29:0]  sad16x8, sad8x16;
  logic [15:0]  sad16x16;

  int total = 0;
  int bad = 0;
  int curPix [16][16];
  int refPix [16][16];

  always #5 clk = ~clk;

  vbsSadTree uut (
    .clk(clk), .rstN(rstN), .start(start), .rowValid(rowValid),
    .curRow(curRow), .refRow(refRow), .done(done),
    .sad4x4(sad4x4), .sad8x4(sad8x4), .sad4x8(sad4x8), .sad8x8(sad8x8),
    .sad16x8(sad16x8), .sad8x16(sad8x16), .sad16x16(sad16x16)
  );

  function automatic int rect(int x0, int y0, int w, int h);
    int s = 0;
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++)
        s += (curPix[y][x] > refPix[y][x]) ? curPix[y][x] - refPix[y][x]
                                           : refPix[y][x] - curPix[y][x];
    return s;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int k = 0; k < 16; k++)
      check("R2", {tag, " 4x4"}, int'(sad4x4[k*12 +: 12]), rect(4*(k%4), 4*(k/4), 4, 4));
    for (int j = 0; j < 8; j++) begin
      check("R3", {tag, " 8x4"}, int'(sad8x4[j*13 +: 13]), rect(8*(j%2), 4*(j/2), 8, 4));
      check("R3", {tag, " 4x8"}, int'(sad4x8[j*13 +: 13]), rect(4*(j%4), 8*(j/4), 4, 8));
    end
    for (int q = 0; q < 4; q++)
      check("R4", {tag, " 8x8"}, int'(sad8x8[q*14 +: 14]), rect(8*(q%2), 8*(q/2), 8, 8));
    for (int h = 0; h < 2; h++) begin
      check("R4", {tag, " 16x8"}, int'(sad16x8[h*15 +: 15]), rect(0, 8*h, 16, 8));
      check("R4", {tag, " 8x16"}, int'(sad8x16[h*15 +: 15]), rect(8*h, 0, 8, 16));
    end
    check("R4", {tag, " 16x16"}, int'(sad16x16), rect(0, 0, 16, 16));
  endtask

  task automatic fillRandom(int maxDelta);
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++) begin
        curPix[y][x] = $urandom_range(255);
        refPix[y][x] = curPix[y][x] + $urandom_range(2*maxDelta) - maxDelta;
        if (refPix[y][x] < 0) refPix[y][x] = 0;
        if (refPix[y][x] > 255) refPix[y][x] = 255;
      end
  endtask

  task automatic pulseStart(bit withRow);
    @(negedge clk);
    start = 1'b1;
    rowValid = withRow;
    curRow = {$urandom, $urandom, $urandom, $urandom};
    refRow = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    start = 1'b0;
    rowValid = 1'b0;
  endtask

  // Streams the 16 rows; maxGap idle junk cycles may precede each row.
  task automatic streamBlock(int maxGap, string tag);
    for (int y = 0; y < 16; y++) begin
      for (int g = 0; g < $urandom_range(maxGap); g++) begin
        rowValid = 1'b0;
        curRow = {$urandom, $urandom, $urandom, $urandom};
        refRow = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        if (done) check("R5", {tag, " early done"}, 1, 0);
      end
      rowValid = 1'b1;
      for (int x = 0; x < 16; x++) begin
        curRow[8*x +: 8] = 8'(curPix[y][x]);
        refRow[8*x +: 8] = 8'(refPix[y][x]);
      end
      @(negedge clk);
      if (y < 15 && done) check("R5", {tag, " early done"}, 1, 0);
    end
    rowValid = 1'b0;
    check("R5", {tag, " done after last row"}, int'(done), 1);
    checkAll(tag);
    @(negedge clk);
    check("R5", {tag, " done one cycle"}, int'(done), 0);
  endtask

  task automatic testReset();
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset 4x4 all", int'(sad4x4 != '0), 0);
    check("R1", "reset 16x16", int'(sad16x16), 0);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 3; i++) begin
      fillRandom(i == 0 ? 255 : 20);
      pulseStart(1'b0);
      streamBlock(0, "random");
    end
  endtask

  task automatic testIdentical();
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++) begin
        curPix[y][x] = $urandom_range(255);
        refPix[y][x] = curPix[y][x];
      end
    pulseStart(1'b0);
    streamBlock(0, "identical");
  endtask

  task automatic testGaps();
    fillRandom(255);
    pulseStart(1'b0);
    streamBlock(3, "R7 gaps");
  endtask

  task automatic testMax();
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++) begin
        curPix[y][x] = ((x + y) % 2) ? 255 : 0;
        refPix[y][x] = 255 - curPix[y][x];
      end
    pulseStart(1'b0);
    streamBlock(0, "R9 max");
    check("R9", "max 4x4", int'(sad4x4[11:0]), 4080);
    check("R9", "max 16x16", int'(sad16x16), 65280);
  endtask

  task automatic testExtraRows();
    int before16, before4;
    fillRandom(255);
    pulseStart(1'b0);
    streamBlock(0, "extra");
    before16 = int'(sad16x16);
    before4 = int'(sad4x4[11:0]);
    for (int i = 0; i < 5; i++) begin
      rowValid = 1'b1;
      curRow = {$urandom, $urandom, $urandom, $urandom};
      refRow = ~curRow;
      @(negedge clk);
      if (done) check("R6", "done after extra row", 1, 0);
    end
    rowValid = 1'b0;
    check("R6", "16x16 held", int'(sad16x16), before16);
    check("R6", "4x4 held", int'(sad4x4[11:0]), before4);
    checkAll("R6 held");
  endtask

  task automatic testStartWithRow();
    pulseStart(1'b1);
    check("R8", "cleared 4x4", int'(sad4x4 != '0), 0);
    check("R8", "cleared 16x16", int'(sad16x16), 0);
    fillRandom(255);
    streamBlock(1, "R8 restart");
  endtask

  initial begin
    #100000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRandom();
    testIdentical();
    testGaps();
    testMax();
    testExtraRows();
    testStartWithRow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule